// File: doc/BRIEF.md
# Operand and Branch Address Generator

This block turns the decoded fields of one instruction of an 8-bit accumulator processor into a single address. Data operands can be a register, a direct address, a register-indirect pointer or an immediate constant. Branch targets can be absolute within the current 2 KB page, or relative to the next instruction. The decoder sends one request per instruction over a valid/ready input. The result comes out one cycle later over a valid/ready output, as a 16-bit value with a kind tag. The tag says whether the value is a data RAM address, an SFR address, a code address or an immediate constant.

A small register file inside the block holds four banks of eight byte registers, 32 bytes in all. Register Rn of bank b sits at physical index b*8+n. A plain write port loads these registers. Indirect operands read their pointer from the register file on the cycle the request is accepted.

Back-pressure works as follows. The output stage holds one result. `in_ready` is high when that slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and its tag do not change. A new request is accepted on any edge where both `in_valid` and `in_ready` are high.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (register) yields address bank*8+regsel with kind 0 (RAM).
- R2: Mode code 1 (direct) yields the zero-extended byte1. The kind is 0 (RAM) when byte1 is 0 to 127, and 1 (SFR) when byte1 is 128 to 255.
- R3: Mode code 2 (indirect) yields the zero-extended content of register R0 or R1 of the active bank, with regsel bit 0 choosing between them. The kind is always 0 (RAM), even when the pointer is 128 or above.
- R4: Mode code 3 yields zero-extended byte1, and mode code 4 yields {byte1, byte2} with byte1 as the high byte. Both use kind 3 (immediate).
- R5: Mode code 5 (absolute) yields {next[15:11], regsel[2:0], byte1} with kind 2 (code). Here next = (pc + ilen) mod 2^16.
- R6: Mode code 6 (relative) yields (next + sign-extended byte1) mod 2^16, with kind 2 (code).
- R7: A result appears with `out_valid` on the first clock edge after its request is accepted. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, the address and kind stay unchanged.
- R8: Mode code 7 is reserved. A request with this code is accepted and produces no result.
- R9: `rf_we` writes `rf_wdata` to register-file index `rf_waddr` on the clock edge. An indirect request accepted on that same edge still reads the older value.
- R10: After reset, `out_valid` is low and every register-file entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| mode | input | 3 | Addressing mode code |
| bank | input | 2 | Active register bank |
| regsel | input | 3 | Register number, or high bits of an absolute target |
| byte1 | input | 8 | First operand byte |
| byte2 | input | 8 | Second operand byte |
| pc | input | 16 | Address of the current instruction |
| ilen | input | 2 | Instruction length in bytes |
| rf_we | input | 1 | Register-file write enable |
| rf_waddr | input | 5 | Register-file write index |
| rf_wdata | input | 8 | Register-file write data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 16 | Computed address or constant |
| out_kind | output | 2 | 0 RAM, 1 SFR, 2 code, 3 immediate |

## Verification
The bench probes the boundary between RAM and SFR at direct addresses 127 and 128. A design that tests the wrong bit would mislabel one side. It also loads an indirect pointer above 127; a design that reused the direct-mode split would tag that access as SFR. Absolute targets are tried where pc+ilen crosses a 2 KB page, and at the 16-bit wrap. Relative targets are tried at both offset extremes and across address wrap. These cases expose a design that builds the target from the current pc, or that zero-extends the offset. Further directed cases cover a stalled output, a reserved mode code, and a register write that coincides with an indirect read. A wrong design would respectively overwrite or drop the held result, emit a spurious result, or return the freshly written value.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [2:0] {
    M_REG   = 3'd0,
    M_DIR   = 3'd1,
    M_IND   = 3'd2,
    M_IMM8  = 3'd3,
    M_IMM16 = 3'd4,
    M_ABS   = 3'd5,
    M_REL   = 3'd6,
    M_RSVD  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    K_RAM  = 2'd0,
    K_SFR  = 2'd1,
    K_CODE = 2'd2,
    K_IMM  = 2'd3
  } akind_e;
endpackage

// File: rtl/opaddr_regfile.sv
module opaddr_regfile #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  // One register per entry; reads see the value before this edge's write.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cells[gi] <= '0;
      else if (we && waddr == IW'(gi))       cells[gi] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/opaddr_operand.sv
module opaddr_operand
  import opaddr_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RSW = 3,
  parameter int BSW = 2,
  localparam int IW = BSW + RSW
) (
  input  logic [2:0]     mode,
  input  logic [BSW-1:0] bank,
  input  logic [RSW-1:0] regsel,
  input  logic [DW-1:0]  byte1,
  input  logic [DW-1:0]  byte2,
  input  logic [DW-1:0]  ptr,
  output logic [IW-1:0]  ptr_idx,
  output logic [AW-1:0]  addr,
  output logic [1:0]     kind
);
  // Indirect pointers live in R0/R1 of the active bank.
  assign ptr_idx = {bank, {(RSW-1){1'b0}}, regsel[0]};

  always_comb begin
    addr = '0;
    kind = K_IMM;
    case (amode_e'(mode))
      M_REG: begin
        addr = AW'({bank, regsel});
        kind = K_RAM;
      end
      M_DIR: begin
        addr = AW'(byte1);
        kind = byte1[DW-1] ? K_SFR : K_RAM;
      end
      M_IND: begin
        addr = AW'(ptr);
        kind = K_RAM;
      end
      M_IMM8: begin
        addr = AW'(byte1);
        kind = K_IMM;
      end
      M_IMM16: begin
        addr = AW'({byte1, byte2});
        kind = K_IMM;
      end
      default: begin
        addr = '0;
        kind = K_IMM;
      end
    endcase
  end
endmodule

// File: rtl/opaddr_branch.sv
module opaddr_branch #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int RSW  = 3,
  parameter int ABSW = 11,
  parameter int LW   = 2,
  localparam int HI  = ABSW - DW
) (
  input  logic [AW-1:0]  pc,
  input  logic [LW-1:0]  ilen,
  input  logic [RSW-1:0] regsel,
  input  logic [DW-1:0]  byte1,
  input  logic           use_rel,
  output logic [AW-1:0]  target
);
  logic [AW-1:0] next_pc;
  logic [AW-1:0] abs_t;
  logic [AW-1:0] rel_t;
  logic [AW-1:0] offs;

  assign next_pc = pc + AW'(ilen);
  assign offs    = {{(AW-DW){byte1[DW-1]}}, byte1};
  assign rel_t   = next_pc + offs;
  assign abs_t   = {next_pc[AW-1:ABSW], regsel[HI-1:0], byte1};
  assign target  = use_rel ? rel_t : abs_t;
endmodule

// File: rtl/opaddr_outreg.sv
module opaddr_outreg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d_addr,
  input  logic [1:0]    d_kind,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_kind
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_kind  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_addr  <= d_addr;
        out_kind  <= d_kind;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int NREG  = 8,
  parameter int NBANK = 4,
  parameter int ABSW  = 11,
  parameter int LW    = 2,
  localparam int RSW  = $clog2(NREG),
  localparam int BSW  = $clog2(NBANK),
  localparam int IW   = RSW + BSW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     mode,
  input  logic [BSW-1:0] bank,
  input  logic [RSW-1:0] regsel,
  input  logic [DW-1:0]  byte1,
  input  logic [DW-1:0]  byte2,
  input  logic [AW-1:0]  pc,
  input  logic [LW-1:0]  ilen,
  input  logic           rf_we,
  input  logic [IW-1:0]  rf_waddr,
  input  logic [DW-1:0]  rf_wdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic [1:0]     out_kind
);
  logic [IW-1:0] ptr_idx;
  logic [DW-1:0] ptr;
  logic [AW-1:0] op_addr, br_addr, sel_addr;
  logic [1:0]    op_kind, sel_kind;
  logic          is_branch, is_rel, accept, load;

  assign is_rel    = (mode == M_REL);
  assign is_branch = (mode == M_ABS) || is_rel;
  assign accept    = in_valid && in_ready;
  assign load      = accept && (mode != M_RSVD);

  opaddr_regfile #(.DW(DW), .DEPTH(NREG*NBANK)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .raddr(ptr_idx), .rdata(ptr)
  );

  opaddr_operand #(.AW(AW), .DW(DW), .RSW(RSW), .BSW(BSW)) u_op (
    .mode(mode), .bank(bank), .regsel(regsel), .byte1(byte1),
    .byte2(byte2), .ptr(ptr), .ptr_idx(ptr_idx),
    .addr(op_addr), .kind(op_kind)
  );

  opaddr_branch #(.AW(AW), .DW(DW), .RSW(RSW), .ABSW(ABSW), .LW(LW)) u_br (
    .pc(pc), .ilen(ilen), .regsel(regsel), .byte1(byte1),
    .use_rel(is_rel), .target(br_addr)
  );

  assign sel_addr = is_branch ? br_addr : op_addr;
  assign sel_kind = is_branch ? 2'(K_CODE) : op_kind;

  opaddr_outreg #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .d_addr(sel_addr),
    .d_kind(sel_kind), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_kind(out_kind)
  );
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RSW = 3,
  parameter int BSW = 2,
  parameter int IW  = 5,
  parameter int LW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2:0]     mode,
  input logic [BSW-1:0] bank,
  input logic [RSW-1:0] regsel,
  input logic [DW-1:0]  byte1,
  input logic [DW-1:0]  byte2,
  input logic [AW-1:0]  pc,
  input logic [LW-1:0]  ilen,
  input logic           rf_we,
  input logic [IW-1:0]  rf_waddr,
  input logic [DW-1:0]  rf_wdata,
  input logic           out_valid,
  input logic           out_ready,
  input logic [AW-1:0]  out_addr,
  input logic [1:0]     out_kind
);
  logic          acc;
  logic [AW-1:0] nxt, rel_exp;
  assign acc     = in_valid && in_ready;
  assign nxt     = pc + AW'(ilen);
  assign rel_exp = nxt + {{(AW-DW){byte1[DW-1]}}, byte1};

  a_r1_reg_addr: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd0 |=> out_valid && out_kind == 2'd0 &&
      out_addr == AW'($past({bank, regsel})));

  a_r2_direct_split: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd1 |=> out_addr == AW'($past(byte1)) &&
      out_kind == ($past(byte1[DW-1]) ? 2'd1 : 2'd0));

  a_r3_indirect_ram: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd2 |=> out_kind == 2'd0 && out_addr[AW-1:DW] == '0);

  a_r5_abs_page: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd5 |=> out_kind == 2'd2 &&
      out_addr[AW-1:11] == $past(nxt[AW-1:11]));

  a_r6_rel_target: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd6 |=> out_kind == 2'd2 && out_addr == $past(rel_exp));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_kind));

  a_r7_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd7 |=> !out_valid);
endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW), .DW(DW), .RSW(RSW), .BSW(BSW),
  .IW(IW), .LW(LW)) u_chk (.*);

// File: tb/tb_opaddr_gen.sv
`timescale 1ns/1ps
module tb_opaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  mode = '0;
  logic [1:0]  bank = '0;
  logic [2:0]  regsel = '0;
  logic [7:0]  byte1 = '0, byte2 = '0;
  logic [15:0] pc = '0;
  logic [1:0]  ilen = '0;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [7:0]  rf_wdata = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [15:0] out_addr;
  logic [1:0]  out_kind;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opaddr_gen dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Issue one request with out_ready high; result checked one edge later.
  task automatic xfer(input logic [2:0] m, input logic [1:0] b, input logic [2:0] r,
                      input logic [7:0] d1, input logic [7:0] d2,
                      input logic [15:0] p, input logic [1:0] l,
                      input string tag, input logic [15:0] ea, input logic [1:0] ek);
    @(negedge clk);
    mode = m; bank = b; regsel = r; byte1 = d1; byte2 = d2; pc = p; ilen = l;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " addr"}, out_addr, ea);
    chk({tag, " kind"}, out_kind, ek);
  endtask

  task automatic rf_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 out_valid after reset", out_valid, 0);
    chk("R7 in_ready after reset", in_ready, 1);
    xfer(3'd2, 2'd3, 3'd1, 8'h0, 8'h0, 16'h0, 2'd1, "R10 rf cleared", 16'h0000, 2'd0);
  endtask

  task automatic t_reg;
    xfer(3'd0, 2'd2, 3'd5, 8'h0, 8'h0, 16'h0, 2'd1, "R1 bank2 r5", 16'd21, 2'd0);
    xfer(3'd0, 2'd3, 3'd7, 8'h0, 8'h0, 16'h0, 2'd1, "R1 bank3 r7", 16'd31, 2'd0);
    xfer(3'd0, 2'd0, 3'd0, 8'h0, 8'h0, 16'h0, 2'd1, "R1 bank0 r0", 16'd0, 2'd0);
  endtask

  task automatic t_direct;
    xfer(3'd1, 2'd0, 3'd0, 8'h7F, 8'h0, 16'h0, 2'd2, "R2 dir 127", 16'h007F, 2'd0);
    xfer(3'd1, 2'd0, 3'd0, 8'h80, 8'h0, 16'h0, 2'd2, "R2 dir 128", 16'h0080, 2'd1);
    xfer(3'd1, 2'd1, 3'd0, 8'hFF, 8'h0, 16'h0, 2'd2, "R2 dir 255", 16'h00FF, 2'd1);
  endtask

  task automatic t_indirect;
    rf_write(5'd8, 8'h9A);
    rf_write(5'd9, 8'h33);
    xfer(3'd2, 2'd1, 3'd0, 8'h0, 8'h0, 16'h0, 2'd1, "R3 ind R0 high ptr", 16'h009A, 2'd0);
    xfer(3'd2, 2'd1, 3'd1, 8'h0, 8'h0, 16'h0, 2'd1, "R3 ind R1", 16'h0033, 2'd0);
    xfer(3'd2, 2'd1, 3'd7, 8'h0, 8'h0, 16'h0, 2'd1, "R3 ind bit0 only", 16'h0033, 2'd0);
  endtask

  task automatic t_imm;
    xfer(3'd3, 2'd0, 3'd0, 8'hC4, 8'h55, 16'h0, 2'd2, "R4 imm8", 16'h00C4, 2'd3);
    xfer(3'd4, 2'd0, 3'd0, 8'h12, 8'h34, 16'h0, 2'd3, "R4 imm16", 16'h1234, 2'd3);
  endtask

  task automatic t_abs;
    xfer(3'd5, 2'd0, 3'd5, 8'h3C, 8'h0, 16'h07FE, 2'd2, "R5 abs page cross", 16'h0D3C, 2'd2);
    xfer(3'd5, 2'd0, 3'd7, 8'hFF, 8'h0, 16'hFFFF, 2'd2, "R5 abs wrap", 16'h07FF, 2'd2);
    xfer(3'd5, 2'd2, 3'd0, 8'h01, 8'h0, 16'hA123, 2'd1, "R5 abs mid", 16'hA001, 2'd2);
  endtask

  task automatic t_rel;
    xfer(3'd6, 2'd0, 3'd0, 8'h80, 8'h0, 16'h1000, 2'd2, "R6 rel -128", 16'h0F82, 2'd2);
    xfer(3'd6, 2'd0, 3'd0, 8'h7F, 8'h0, 16'h1000, 2'd2, "R6 rel +127", 16'h1081, 2'd2);
    xfer(3'd6, 2'd0, 3'd0, 8'h05, 8'h0, 16'hFFFE, 2'd3, "R6 rel wrap up", 16'h0006, 2'd2);
    xfer(3'd6, 2'd0, 3'd0, 8'hFC, 8'h0, 16'h0000, 2'd2, "R6 rel wrap down", 16'hFFFE, 2'd2);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    mode = 3'd0; bank = 2'd1; regsel = 3'd2; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R7 first result valid", out_valid, 1);
    chk("R7 first result addr", out_addr, 16'd10);
    chk("R7 in_ready low when full", in_ready, 0);
    mode = 3'd3; byte1 = 8'hEE;
    @(negedge clk);
    chk("R7 held addr", out_addr, 16'd10);
    chk("R7 held kind", out_kind, 2'd0);
    @(negedge clk);
    chk("R7 still held", out_addr, 16'd10);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 second result addr", out_addr, 16'h00EE);
    chk("R7 second result kind", out_kind, 2'd3);
    @(negedge clk);
    chk("R7 drained", out_valid, 0);
  endtask

  task automatic t_reserved;
    xfer(3'd0, 2'd0, 3'd3, 8'h0, 8'h0, 16'h0, 2'd1, "R8 before", 16'd3, 2'd0);
    @(negedge clk);
    mode = 3'd7; in_valid = 1'b1; out_ready = 1'b1;
    chk("R8 reserved taken", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 reserved no result", out_valid, 0);
  endtask

  task automatic t_rf_same_cycle;
    rf_write(5'd0, 8'h11);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'd0; rf_wdata = 8'h22;
    mode = 3'd2; bank = 2'd0; regsel = 3'd0; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    rf_we = 1'b0; in_valid = 1'b0;
    chk("R9 same-edge write unseen", out_addr, 16'h0011);
    xfer(3'd2, 2'd0, 3'd0, 8'h0, 8'h0, 16'h0, 2'd1, "R9 write seen later", 16'h0022, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg();
    t_direct();
    t_indirect();
    t_imm();
    t_abs();
    t_rel();
    t_backpressure();
    t_reserved();
    t_rf_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule